// File: doc/BRIEF.md
# I2C GPIO Expander Core

This block is an eight-pin general-purpose I/O expander that a host reaches over a two-wire bus as a target device. SCL and SDA are sampled with the block's own clock. A frame begins with a 7-bit address whose upper four bits are fixed and whose low three bits come from strap inputs. A command byte follows it. The command byte loads a register pointer that picks one of four byte-wide registers: input port (read-only), output port, polarity inversion and configuration. Data bytes are then written to, or read from, that register. The pointer stays loaded after the frame ends, so later reads return the same register until another command byte arrives.

Each pin has a direction bit. A configuration bit of 1 makes the pin an input and turns its pad driver off. A bit of 0 drives the pin from the output-port register. Each input pin is passed through a two-flop synchronizer. A polarity-inversion mask is applied to the pin values when the input port is read. An active-low interrupt output reports that an input-configured pin differs from the value seen at the last input-port read.

The protocol controller is a state machine with nine states:
- ST_IDLE waits for a start.
- ST_ADDR shifts in the address byte.
- ST_ACK_ADDR acknowledges a matching address.
- ST_CMD shifts in the command byte.
- ST_ACK_CMD acknowledges a valid command.
- ST_WDATA shifts in a data byte.
- ST_ACK_WDATA acknowledges that byte after the register write.
- ST_RDATA shifts a register byte out on SDA.
- ST_RACK samples the host's acknowledge.

The transitions are as follows:
- A start moves any state to ST_ADDR, and a stop moves any state to ST_IDLE.
- At the eighth SCL fall, ST_ADDR goes to ST_ACK_ADDR on a match and to ST_IDLE otherwise.
- At the end of the ninth pulse, ST_ACK_ADDR goes to ST_RDATA (read) or ST_CMD (write).
- ST_CMD goes to ST_ACK_CMD for commands 0 to 3 and to ST_IDLE for any other value.
- ST_ACK_CMD goes to ST_WDATA.
- ST_WDATA goes to ST_ACK_WDATA and writes the register.
- ST_ACK_WDATA goes back to ST_WDATA.
- ST_RDATA goes to ST_RACK after eight bits.
- ST_RACK goes to ST_RDATA on an ACK and reloads the byte, or to ST_IDLE on a NACK.

Top module: `i2c_gpio_expander`

## Requirements
- R1: After reset, pin_oe is 0x00 (every pin an input), int_n is 1 and sda_oe is 0. A register read then returns output port 0xFF, polarity 0x00 and configuration 0xFF.
- R2: The target acknowledges (sda_oe=1 through the ninth SCL pulse) only the address {0100, addr_strap[2:0]}, followed by an R/W bit (0 = write, 1 = read). Any other address gets no acknowledge.
- R3: Command byte values 0 (input), 1 (output), 2 (polarity) and 3 (configuration) are acknowledged and load the pointer. Any other value is not acknowledged and leaves the pointer unchanged.
- R4: A configuration bit of 1 gives pin_oe bit 0 (input), and a bit of 0 gives pin_oe bit 1 (output).
- R5: pin_o carries the output-port register. A read of register 1 returns the stored byte, not the pin level.
- R6: A read of register 0 returns each synchronized pin bit XOR the matching polarity-inversion bit.
- R7: The pointer persists across frames. A read frame without a command byte returns the register last selected.
- R8: int_n goes low when an input-configured pin differs from its value at the last input-port read. Changes on output-configured pins have no effect. int_n returns high on a read of register 0. The reference value is 0xFF after reset.
- R9: Several data bytes in one frame all address the same register. Several bytes read in one frame all return the selected register.
- R10: A data byte written with pointer 0 is acknowledged and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_strap | input | 3 | Low three address bits |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad driver enables, 1 = drive |
| int_n | output | 1 | Active-low change interrupt |

## Verification
The bench probes the following corner cases:
- A wrong strap address, which a loose compare would acknowledge.
- An out-of-range command, where a design that latched it would then read back the wrong register.
- A read of the output register while the pins show other values, which exposes a design that returns pin levels.
- A pin change on an output-configured pin, which must not raise the interrupt.
- Repeated reads after a single command byte, which expose a pointer that auto-increments or clears at stop.
- A write to the input index, which a faulty decode would let corrupt another register.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        REG_INPUT    = 2'd0,
        REG_OUTPUT   = 2'd1,
        REG_POLARITY = 2'd2,
        REG_CONFIG   = 2'd3
    } gpx_reg_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_CMD,
        ST_ACK_CMD,
        ST_WDATA,
        ST_ACK_WDATA,
        ST_RDATA,
        ST_RACK
    } gpx_state_e;

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RST_VAL;
            else        stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_line_events.sv
module gpx_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/gpx_i2c_fsm.sv
module gpx_i2c_fsm
    import gpx_pkg::*;
#(
    parameter int           STRAP_W = 3,
    parameter logic [6-STRAP_W:0] ADDR_HI = 4'b0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_load,
    output gpx_reg_e          ptr,
    output gpx_state_e        state_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_IN  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_OUT = CNT_W'(BYTE_W - 1);

    gpx_state_e        state_q, state_d;
    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    gpx_reg_e          ptr_q;
    logic              mack_q;
    logic              cmd_take;
    logic              shift_in;
    logic              addr_hit;
    logic              cmd_ok;

    assign addr_hit = (sh_q[BYTE_W-1:1] == {ADDR_HI, strap});
    assign cmd_ok   = (sh_q[BYTE_W-1:2] == '0);
    assign shift_in = (state_q == ST_ADDR) || (state_q == ST_CMD) || (state_q == ST_WDATA);

    // next state and strobes
    always_comb begin
        state_d  = state_q;
        wr_en    = 1'b0;
        rd_load  = 1'b0;
        cmd_take = 1'b0;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR:
                    if (scl_fall && cnt_q == LAST_IN)
                        state_d = addr_hit ? ST_ACK_ADDR : ST_IDLE;
                ST_ACK_ADDR:
                    if (scl_fall) begin
                        if (sh_q[0]) begin
                            state_d = ST_RDATA;
                            rd_load = 1'b1;
                        end else begin
                            state_d = ST_CMD;
                        end
                    end
                ST_CMD:
                    if (scl_fall && cnt_q == LAST_IN) begin
                        if (cmd_ok) begin
                            state_d  = ST_ACK_CMD;
                            cmd_take = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                ST_ACK_CMD:
                    if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:
                    if (scl_fall && cnt_q == LAST_IN) begin
                        state_d = ST_ACK_WDATA;
                        wr_en   = 1'b1;
                    end
                ST_ACK_WDATA:
                    if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:
                    if (scl_fall && cnt_q == LAST_OUT) state_d = ST_RACK;
                ST_RACK:
                    if (scl_fall) begin
                        if (mack_q) begin
                            state_d = ST_RDATA;
                            rd_load = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift, count and pointer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            ptr_q  <= REG_INPUT;
            mack_q <= 1'b0;
        end else begin
            if (start_det || state_d != state_q)
                cnt_q <= '0;
            else if ((shift_in && scl_rise) || (state_q == ST_RDATA && scl_fall))
                cnt_q <= cnt_q + 1'b1;

            if (rd_load)
                sh_q <= rd_data;
            else if (shift_in && scl_rise)
                sh_q <= {sh_q[BYTE_W-2:0], sda_s};
            else if (state_q == ST_RDATA && scl_fall)
                sh_q <= {sh_q[BYTE_W-2:0], 1'b1};

            if (cmd_take)
                ptr_q <= gpx_reg_e'(sh_q[1:0]);

            if (state_q == ST_RACK && scl_rise)
                mack_q <= ~sda_s;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ACK_ADDR, ST_ACK_CMD, ST_ACK_WDATA: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~sh_q[BYTE_W-1];
            default:                               sda_oe = 1'b0;
        endcase
    end

    assign wr_data = sh_q;
    assign ptr     = ptr_q;
    assign state_o = state_q;
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int PINS = BYTE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PINS-1:0] wr_data,
    input  gpx_reg_e        ptr,
    input  logic            rd_load,
    input  logic [PINS-1:0] pin_s,
    output logic [PINS-1:0] rd_data,
    output logic [PINS-1:0] out_q,
    output logic [PINS-1:0] cfg_q,
    output logic            int_n
);
    logic [PINS-1:0] pol_q;
    logic [PINS-1:0] snap_q;
    logic            int_n_q;
    logic            in_read;
    logic [PINS-1:0] changed;

    assign in_read = rd_load && (ptr == REG_INPUT);
    assign changed = (pin_s ^ snap_q) & cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '1;
            pol_q <= '0;
            cfg_q <= '1;
        end else if (wr_en) begin
            unique case (ptr)
                REG_INPUT:    ;
                REG_OUTPUT:   out_q <= wr_data;
                REG_POLARITY: pol_q <= wr_data;
                REG_CONFIG:   cfg_q <= wr_data;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q  <= '1;
            int_n_q <= 1'b1;
        end else if (in_read) begin
            snap_q  <= pin_s;
            int_n_q <= 1'b1;
        end else begin
            int_n_q <= ~(|changed);
        end
    end

    always_comb begin
        unique case (ptr)
            REG_INPUT:    rd_data = pin_s ^ pol_q;
            REG_OUTPUT:   rd_data = out_q;
            REG_POLARITY: rd_data = pol_q;
            REG_CONFIG:   rd_data = cfg_q;
            default:      rd_data = '0;
        endcase
    end

    assign int_n = int_n_q;
endmodule

// File: rtl/i2c_gpio_expander.sv
module i2c_gpio_expander
    import gpx_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         STRAP_W     = 3,
    parameter logic [3:0] ADDR_HI     = 4'b0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] addr_strap,
    input  logic [BYTE_W-1:0]  pin_i,
    output logic [BYTE_W-1:0]  pin_o,
    output logic [BYTE_W-1:0]  pin_oe,
    output logic               int_n
);
    logic              scl_s, sda_s;
    logic [1:0]        bus_s;
    logic [BYTE_W-1:0] pin_s;
    logic              scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en, rd_load;
    logic [BYTE_W-1:0] wr_data, rd_data, out_q, cfg_q;
    gpx_reg_e          ptr;
    gpx_state_e        fsm_state;

    gpx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
    );
    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    gpx_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL({BYTE_W{1'b1}})) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s)
    );

    gpx_line_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    gpx_i2c_fsm #(.STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_s(sda_s), .strap(addr_strap), .rd_data(rd_data),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_data(wr_data),
        .rd_load(rd_load), .ptr(ptr), .state_o(fsm_state)
    );

    gpx_regs #(.PINS(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ptr(ptr), .rd_load(rd_load), .pin_s(pin_s),
        .rd_data(rd_data), .out_q(out_q), .cfg_q(cfg_q), .int_n(int_n)
    );

    assign pin_o  = out_q;
    assign pin_oe = ~cfg_q;
endmodule

// File: rtl/gpx_checker.sv
module gpx_checker
    import gpx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_oe,
    input logic              wr_en,
    input logic              rd_load,
    input gpx_reg_e          ptr,
    input gpx_state_e        state,
    input logic [BYTE_W-1:0] pin_o,
    input logic [BYTE_W-1:0] pin_oe,
    input logic              int_n
);
    // R2: the target never pulls SDA while idle
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R2: SDA drive only changes while SCL is low
    a_r2_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R4: direction changes only after a configuration write
    a_r4_dir_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_oe) |-> ($past(wr_en) && $past(ptr) == REG_CONFIG));

    // R5: output levels change only after an output-port write
    a_r5_out_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_o) |-> ($past(wr_en) && $past(ptr) == REG_OUTPUT));

    // R8: reading the input port releases the interrupt
    a_r8_int_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_load && ptr == REG_INPUT) |=> int_n);

    // R9: a write strobe and a read load never coincide
    a_r9_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, rd_load}));
endmodule

bind i2c_gpio_expander gpx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .wr_en(wr_en), .rd_load(rd_load), .ptr(ptr), .state(fsm_state),
    .pin_o(pin_o), .pin_oe(pin_oe), .int_n(int_n)
);

// File: tb/sim_i2c_gpio_expander.sv
module sim_i2c_gpio_expander;
    localparam int H = 16;
    localparam logic [6:0] DEV = 7'b0100_101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_oe;
    logic [2:0] strap = 3'b101;
    logic [7:0] pin_i = 8'hFF;
    logic [7:0] pin_o, pin_oe;
    logic       int_n;
    wire        sda_line = sda_m & ~sda_oe;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs_q[$];

    always #4 clk = ~clk;

    i2c_gpio_expander u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_strap(strap), .pin_i(pin_i),
        .pin_o(pin_o), .pin_oe(pin_oe), .int_n(int_n)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_w(logic b);
        tick(4); sda_m = b; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0;
    endtask

    task automatic bit_r(output logic b);
        tick(4); sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H); b = sda_line; scl_m = 1'b0;
    endtask

    task automatic i2c_start();
        tick(4); sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H); scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        tick(4); sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
    endtask

    task automatic wbyte(logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_w(d[i]);
        bit_r(b);
        ack = ~b;
    endtask

    task automatic rbyte(logic last, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_r(d[i]);
        bit_w(last);
    endtask

    // driver: expected bytes into the scoreboard
    task automatic expect_byte(string tag, logic [7:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic read_frame(int n);
        logic ack;
        logic [7:0] d;
        i2c_start();
        wbyte({DEV, 1'b1}, ack);
        chk("R2 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            rbyte(i == n - 1, d);
            obs_q.push_back(d);
        end
        i2c_stop();
    endtask

    task automatic select_reg(logic [7:0] cmd, logic exp_ack);
        logic ack;
        i2c_start();
        wbyte({DEV, 1'b0}, ack);
        chk("R2 write address ack", ack, 1);
        wbyte(cmd, ack);
        chk("R3 command ack", ack, exp_ack);
        i2c_stop();
    endtask

    task automatic write_reg(logic [7:0] cmd, logic [7:0] d);
        logic ack;
        i2c_start();
        wbyte({DEV, 1'b0}, ack);
        chk("R2 write address ack", ack, 1);
        wbyte(cmd, ack);
        chk("R3 command ack", ack, 1);
        wbyte(d, ack);
        chk("R10 data ack", ack, 1);
        i2c_stop();
    endtask

    // monitor: compare observed read bytes against the expected queue
    initial begin
        forever begin
            wait (obs_q.size() != 0);
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard unexpected byte actual=%0h expected=none", obs_q.pop_front());
            end else begin
                chk(tag_q.pop_front(), obs_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog all requirements actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1 reset state at the ports
        chk("R1 pin_oe reset", pin_oe, 8'h00);
        chk("R1 int_n reset", int_n, 1);
        chk("R1 sda_oe reset", sda_oe, 0);

        // R2 wrong strap bits get no acknowledge
        i2c_start();
        wbyte({7'b0100_100, 1'b0}, ack);
        chk("R2 foreign address nack", ack, 0);
        i2c_stop();

        // R1 reset register contents
        select_reg(8'd1, 1); expect_byte("R1 output reset", 8'hFF); read_frame(1);
        select_reg(8'd2, 1); expect_byte("R1 polarity reset", 8'h00); read_frame(1);
        select_reg(8'd3, 1); expect_byte("R1 config reset", 8'hFF); read_frame(1);

        // R3 bad command: nack, pointer stays on config
        select_reg(8'd4, 0);
        expect_byte("R3 pointer kept after bad command", 8'hFF); read_frame(1);

        // R4 direction
        write_reg(8'd3, 8'hF0);
        tick(4);
        chk("R4 pin_oe from config", pin_oe, 8'h0F);

        // R5 output register versus pins
        pin_i = 8'h00;
        write_reg(8'd1, 8'h5A);
        tick(4);
        chk("R5 pin_o level", pin_o, 8'h5A);
        select_reg(8'd1, 1);
        expect_byte("R5 output reads flip-flop", 8'h5A); read_frame(1);

        // R7 pointer persists across frames
        expect_byte("R7 repeated read", 8'h5A); read_frame(1);

        // R6 polarity inversion
        pin_i = 8'h3C;
        select_reg(8'd0, 1);
        expect_byte("R6 no inversion", 8'h3C); read_frame(1);
        write_reg(8'd2, 8'hFF);
        select_reg(8'd0, 1);
        expect_byte("R6 full inversion", 8'hC3); read_frame(1);
        write_reg(8'd2, 8'h0F);
        select_reg(8'd0, 1);
        expect_byte("R6 partial inversion", 8'h33); read_frame(1);

        // R9 two data bytes in one frame go to the same register
        i2c_start();
        wbyte({DEV, 1'b0}, ack); chk("R9 address ack", ack, 1);
        wbyte(8'd2, ack);        chk("R9 command ack", ack, 1);
        wbyte(8'h11, ack);       chk("R9 first data ack", ack, 1);
        wbyte(8'h22, ack);       chk("R9 second data ack", ack, 1);
        i2c_stop();
        expect_byte("R9 burst read 0", 8'h22);
        expect_byte("R9 burst read 1", 8'h22);
        expect_byte("R9 burst read 2", 8'h22);
        read_frame(3);

        // R8 interrupt: pol 0, cfg F0, pins 3C snapshotted by a read
        write_reg(8'd2, 8'h00);
        select_reg(8'd0, 1);
        expect_byte("R8 snapshot read", 8'h3C); read_frame(1);
        tick(6);
        chk("R8 idle after read", int_n, 1);
        pin_i = 8'h3D;  // output-configured bit 0 changes
        tick(8);
        chk("R8 output pin ignored", int_n, 1);
        pin_i = 8'hBD;  // input-configured bit 7 changes
        tick(8);
        chk("R8 input change asserts", int_n, 0);
        expect_byte("R8 clearing read", 8'hBD); read_frame(1);
        tick(6);
        chk("R8 cleared by input read", int_n, 1);

        // R10 write to input index is acked and ignored
        write_reg(8'd0, 8'h00);
        expect_byte("R10 input unaffected", 8'hBD); read_frame(1);
        select_reg(8'd3, 1);
        expect_byte("R10 config unaffected", 8'hF0); read_frame(1);
        select_reg(8'd1, 1);
        expect_byte("R10 output unaffected", 8'h5A); read_frame(1);
        chk("R10 pin_o unaffected", pin_o, 8'h5A);

        wait (obs_q.size() == 0);
        tick(4);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard missing bytes actual=%0d expected=0", exp_q.size());
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule